// File: doc/BRIEF.md
# Conversion Start and Busy Sequencer

This block decides when a data converter's sample-and-hold leaves tracking and the conversion runs. It times an acquisition window in system clocks, then chooses between two ways of starting. If the start request input is low as the window closes, the block enters hold and begins converting in the next cycle. If the input is high at that moment, the block waits for the request to fall and starts on that edge. This lets a host place the sampling instant precisely when low jitter matters, or simply let the converter run free.

A counter of fixed, parameterised length stands in for the analog conversion. While it runs, `busy_o` and `hold_o` are high, and `conv_go_o` pulses in the first converting cycle. The value on `sample_i` is captured on the edge that enters hold. When the counter expires, that value moves into the output register `result_o`, and `data_rdy_o` pulses in the same cycle that busy falls. A power-down request lets a running conversion finish and then keeps the block idle. A synchronous reset aborts any conversion and leaves the last result in place.

The state machine has four states. `ST_ACQUIRE` times the acquisition window. `ST_WAIT_EDGE` waits for a falling start request. `ST_CONVERT` runs the conversion counter. `ST_IDLE_PD` is held while powered down. Its transitions are:

- ACQUIRE→IDLE_PD when power-down is high.
- ACQUIRE→CONVERT at window end when the start input is low.
- ACQUIRE→WAIT_EDGE at window end when the start input is high.
- WAIT_EDGE→IDLE_PD when power-down is high.
- WAIT_EDGE→CONVERT on a falling edge of the start input.
- CONVERT→ACQUIRE at counter end when power-down is low.
- CONVERT→IDLE_PD at counter end when power-down is high.
- IDLE_PD→ACQUIRE when power-down is released.
- Reset sends any state to ACQUIRE.

Top module: `cnv_seq_top`

## Requirements
- R1: After reset is released, or after power-down is released, the block stays in acquisition for ACQ_CYC full clocks before any conversion can begin. With the start input held low, `busy_o` is first high ACQ_CYC clocks after the first unreset edge, or ACQ_CYC+1 clocks after power-down is sampled low.
- R2: If `start_i` is sampled low in the last acquisition cycle (and power-down is low), `busy_o` and `hold_o` are high in the very next cycle.
- R3: If `start_i` is sampled high in the last acquisition cycle, no conversion starts while it stays high. Conversion begins in the cycle after the first edge at which `start_i` is sampled low, having been sampled high at the edge before.
- R4: A conversion keeps `busy_o` and `hold_o` high for exactly CNV_CYC consecutive cycles. `conv_go_o` is high only in the first of them.
- R5: The `sample_i` value sampled at the edge that enters conversion appears on `result_o` in the first cycle that `busy_o` is low again. `data_rdy_o` is high for exactly that one cycle.
- R6: A falling edge on `start_i` during acquisition or during conversion does not start a conversion. Only the level at the close of acquisition, and edges after it, matter.
- R7: Power-down sampled high during acquisition or waiting stops any conversion from starting. Power-down during a conversion lets that conversion complete and deliver its result, after which no conversion starts while power-down remains high.
- R8: Reset sampled high drives `busy_o`, `hold_o`, `conv_go_o` and `data_rdy_o` low in the next cycle and leaves `result_o` unchanged.
- R9: After a conversion ends with power-down low, a new full acquisition of ACQ_CYC clocks precedes the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, aborts conversion |
| start_i | input | 1 | Conversion start request, level and falling edge used |
| pwr_down_i | input | 1 | Power-down request |
| sample_i | input | DW | Stand-in for the analog value to be held |
| hold_o | output | 1 | Sample-and-hold in hold mode |
| conv_go_o | output | 1 | One-cycle pulse at conversion start |
| busy_o | output | 1 | High while a conversion runs |
| data_rdy_o | output | 1 | One-cycle pulse when a new result is latched |
| result_o | output | DW | Latched conversion result |

## Verification
All outputs are registered. The effect of an input sampled at a rising edge is therefore visible from that edge on, and the bench reads every output at the following falling edge. An immediate start is due one cycle after the last acquisition edge. An edge-triggered start is due one cycle after the edge that sees the start request low. The result and data-ready pulse arrive in the cycle after the CNV_CYC-th converting cycle. A behavioural reference model steps on each rising edge and is compared on every falling edge. Directed checks count the exact number of falling edges between reset release, power-down release or the end of busy and the next rising busy, and compare that count against ACQ_CYC.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

    typedef enum logic [1:0] {
        ST_ACQUIRE   = 2'd0,
        ST_WAIT_EDGE = 2'd1,
        ST_CONVERT   = 2'd2,
        ST_IDLE_PD   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/cnv_edge_watch.sv
module cnv_edge_watch (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic fall_o
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_i;
        end
    end

    assign fall_o = level_q & ~level_i;

endmodule

// File: rtl/cnv_phase_timer.sv
module cnv_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart_i,
    input  logic [CW-1:0] lim_i,
    output logic          done_o,
    output logic          first_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != lim_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o  = (cnt_q == lim_i);
    assign first_o = (cnt_q == '0);

    // R4: the phase counter never runs past the limit of its phase
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_i);

endmodule

// File: rtl/cnv_result_latch.sv
module cnv_result_latch #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture_i,
    input  logic          commit_i,
    input  logic [DW-1:0] sample_i,
    output logic [DW-1:0] result_o,
    output logic          rdy_o
);

    logic [DW-1:0] held_q;
    logic [DW-1:0] result_q;
    logic          rdy_q;

    // held value and result carry no reset so that reset keeps the last result
    always_ff @(posedge clk) begin
        if (capture_i) begin
            held_q <= sample_i;
        end
        if (commit_i && !rst) begin
            result_q <= held_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= commit_i;
        end
    end

    assign result_o = result_q;
    assign rdy_o    = rdy_q;

    // R8: the result only moves on a commit
    a_r8_result_kept: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(result_o));

    // R5: ready pulse lasts one cycle
    a_r5_rdy_single: assert property (@(posedge clk) disable iff (rst)
        rdy_o |=> !rdy_o);

endmodule

// File: rtl/cnv_seq_fsm.sv
module cnv_seq_fsm
    import cnv_seq_pkg::*;
#(
    parameter int CW      = 4,
    parameter int ACQ_CYC = 8,
    parameter int CNV_CYC = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          pd_i,
    input  logic          fall_i,
    input  logic          tmr_done_i,
    input  logic          tmr_first_i,
    output logic          tmr_restart_o,
    output logic [CW-1:0] tmr_lim_o,
    output logic          capture_o,
    output logic          commit_o,
    output logic          hold_o,
    output logic          conv_go_o,
    output logic          busy_o
);

    localparam logic [CW-1:0] ACQ_LIM = CW'(ACQ_CYC - 1);
    localparam logic [CW-1:0] CNV_LIM = CW'(CNV_CYC - 1);

    seq_state_t state_q;
    seq_state_t state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (pd_i) begin
                    state_d = ST_IDLE_PD;
                end else if (tmr_done_i) begin
                    state_d = start_i ? ST_WAIT_EDGE : ST_CONVERT;
                end
            end
            ST_WAIT_EDGE: begin
                if (pd_i) begin
                    state_d = ST_IDLE_PD;
                end else if (fall_i) begin
                    state_d = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (tmr_done_i) begin
                    state_d = pd_i ? ST_IDLE_PD : ST_ACQUIRE;
                end
            end
            ST_IDLE_PD: begin
                if (!pd_i) begin
                    state_d = ST_ACQUIRE;
                end
            end
            default: state_d = ST_ACQUIRE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACQUIRE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and timer control
    always_comb begin
        tmr_restart_o = (state_d != state_q);
        capture_o     = (state_q != ST_CONVERT) && (state_d == ST_CONVERT);
        commit_o      = (state_q == ST_CONVERT) && tmr_done_i;
        hold_o        = 1'b0;
        busy_o        = 1'b0;
        conv_go_o     = 1'b0;
        tmr_lim_o     = '0;
        unique case (state_q)
            ST_ACQUIRE: tmr_lim_o = ACQ_LIM;
            ST_CONVERT: begin
                tmr_lim_o = CNV_LIM;
                hold_o    = 1'b1;
                busy_o    = 1'b1;
                conv_go_o = tmr_first_i;
            end
            ST_WAIT_EDGE, ST_IDLE_PD: tmr_lim_o = '0;
            default: tmr_lim_o = '0;
        endcase
    end

    // R2: low start level at acquisition end starts at once
    a_r2_level_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACQUIRE && tmr_done_i && !start_i && !pd_i) |=> busy_o);

    // R3: a falling start request while waiting starts conversion
    a_r3_edge_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_EDGE && fall_i && !pd_i) |=> busy_o);

    // R6: busy rises only out of an acquisition end or a wait
    a_r6_no_stray_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past((state_q == ST_ACQUIRE && tmr_done_i) || state_q == ST_WAIT_EDGE));

    // R4: conversion begins with the go pulse
    a_r4_go_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> conv_go_o);

    // R7: no conversion while powered down
    a_r7_pd_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE_PD && pd_i) |=> !busy_o);

    // R8: reset clears busy in one clock
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> !busy_o && !hold_o);

endmodule

// File: rtl/cnv_seq_top.sv
module cnv_seq_top #(
    parameter int DW      = 16,
    parameter int ACQ_CYC = 8,
    parameter int CNV_CYC = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          pwr_down_i,
    input  logic [DW-1:0] sample_i,
    output logic          hold_o,
    output logic          conv_go_o,
    output logic          busy_o,
    output logic          data_rdy_o,
    output logic [DW-1:0] result_o
);

    localparam int MAX_CYC = (ACQ_CYC > CNV_CYC) ? ACQ_CYC : CNV_CYC;
    localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic          fall;
    logic          tmr_done;
    logic          tmr_first;
    logic          tmr_restart;
    logic [CW-1:0] tmr_lim;
    logic          capture;
    logic          commit;
    logic          busy;

    cnv_edge_watch u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (start_i),
        .fall_o  (fall)
    );

    cnv_phase_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (tmr_restart),
        .lim_i     (tmr_lim),
        .done_o    (tmr_done),
        .first_o   (tmr_first)
    );

    cnv_seq_fsm #(.CW(CW), .ACQ_CYC(ACQ_CYC), .CNV_CYC(CNV_CYC)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .pd_i          (pwr_down_i),
        .fall_i        (fall),
        .tmr_done_i    (tmr_done),
        .tmr_first_i   (tmr_first),
        .tmr_restart_o (tmr_restart),
        .tmr_lim_o     (tmr_lim),
        .capture_o     (capture),
        .commit_o      (commit),
        .hold_o        (hold_o),
        .conv_go_o     (conv_go_o),
        .busy_o        (busy)
    );

    cnv_result_latch #(.DW(DW)) u_result (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .commit_i  (commit),
        .sample_i  (sample_i),
        .result_o  (result_o),
        .rdy_o     (data_rdy_o)
    );

    assign busy_o = busy;

    // R5: a conversion that ends normally is followed by a ready pulse
    a_r5_rdy_on_fall: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && !$past(rst)) |-> data_rdy_o);

endmodule

// File: tb/tb_cnv_seq_top.sv
module tb_cnv_seq_top;

    localparam int DW  = 16;
    localparam int ACQ = 8;
    localparam int CNV = 12;

    localparam int M_ACQ  = 0;
    localparam int M_WAIT = 1;
    localparam int M_CONV = 2;
    localparam int M_IDLE = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          pd = 1'b0;
    logic [DW-1:0] sample = 16'h1234;
    logic          hold, go, busy, rdy;
    logic [DW-1:0] result;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cnv_seq_top #(.DW(DW), .ACQ_CYC(ACQ), .CNV_CYC(CNV)) dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .pwr_down_i (pd),
        .sample_i   (sample),
        .hold_o     (hold),
        .conv_go_o  (go),
        .busy_o     (busy),
        .data_rdy_o (rdy),
        .result_o   (result)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model, stepped on each rising edge
    int            m_st = M_ACQ;
    int            m_cnt = 0;
    bit            m_prev = 1'b0;
    bit            m_rdy = 1'b0;
    bit            m_valid = 1'b0;
    logic [DW-1:0] m_held = '0;
    logic [DW-1:0] m_res = '0;

    always @(posedge clk) begin
        int  nx;
        bit  fell;
        cyc++;
        if (rst) begin
            m_st = M_ACQ;
            m_cnt = 0;
            m_prev = 1'b0;
            m_rdy = 1'b0;
        end else begin
            fell = m_prev && !start;
            nx = m_st;
            m_rdy = 1'b0;
            case (m_st)
                M_ACQ:  if (pd) nx = M_IDLE; else if (m_cnt == ACQ - 1) nx = start ? M_WAIT : M_CONV;
                M_WAIT: if (pd) nx = M_IDLE; else if (fell) nx = M_CONV;
                M_CONV: if (m_cnt == CNV - 1) begin
                            nx = pd ? M_IDLE : M_ACQ;
                            m_rdy = 1'b1;
                            m_res = m_held;
                            m_valid = 1'b1;
                        end
                default: if (!pd) nx = M_ACQ;
            endcase
            if (nx == M_CONV && m_st != M_CONV) m_held = sample;
            m_cnt = (nx != m_st) ? 0 : m_cnt + 1;
            m_st = nx;
            m_prev = start;
        end
    end

    // compare with the model on every falling edge
    always @(negedge clk) begin
        chk("R4 busy vs model", busy, m_st == M_CONV);
        chk("R2 hold vs model", hold, m_st == M_CONV);
        chk("R4 go vs model", go, (m_st == M_CONV) && (m_cnt == 0));
        chk("R5 rdy vs model", rdy, m_rdy);
        if (m_valid) chk("R5 result vs model", result, m_res);
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 50000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_busy(input logic lvl);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (busy === lvl) return;
        end
        chk("wait timeout", busy, lvl);
    endtask

    // counts falling edges until busy is seen high
    task automatic count_to_busy(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (busy === 1'b1) return;
        end
    endtask

    initial begin
        int n;
        logic [DW-1:0] keep;
        repeat (3) @(negedge clk);
        chk("R8 busy in reset", busy, 1'b0);
        chk("R8 rdy in reset", rdy, 1'b0);
        rst = 1'b0;

        // R1 and R2: free-running start with request low
        count_to_busy(n);
        chk("R1 acquisition after reset", n, ACQ);
        chk("R4 go at first cycle", go, 1'b1);
        sample = 16'hBEEF;
        n = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (busy !== 1'b1) break;
            n++;
        end
        chk("R4 busy length", n, CNV);
        chk("R5 rdy at busy fall", rdy, 1'b1);
        chk("R5 held sample", result, 16'h1234);
        count_to_busy(n);
        chk("R9 new acquisition", n, ACQ);

        // R3: request high at acquisition end waits for its fall
        start = 1'b1;
        wait_busy(1'b0);
        repeat (ACQ + 5) @(negedge clk);
        chk("R3 waits while high", busy, 1'b0);
        start = 1'b0;
        @(negedge clk);
        chk("R3 starts after fall", busy, 1'b1);

        // R6: falls inside conversion and acquisition are ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        wait_busy(1'b0);
        repeat (2) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        repeat (ACQ + 3) @(negedge clk);
        chk("R6 stray falls ignored", busy, 1'b0);
        start = 1'b0;
        @(negedge clk);
        chk("R3 edge start after wait", busy, 1'b1);

        // R7: power-down during conversion lets it finish, then idles
        sample = 16'h5A5A;
        repeat (2) @(negedge clk);
        pd = 1'b1;
        wait_busy(1'b0);
        chk("R7 conversion completes", rdy, 1'b1);
        repeat (30) @(negedge clk);
        chk("R7 no start in power-down", busy, 1'b0);
        pd = 1'b0;
        count_to_busy(n);
        chk("R1 acquisition after power-down", n, ACQ + 1);

        // R7: power-down during acquisition
        wait_busy(1'b0);
        @(negedge clk);
        pd = 1'b1;
        repeat (ACQ + 4) @(negedge clk);
        chk("R7 pd in acquisition", busy, 1'b0);
        pd = 1'b0;
        wait_busy(1'b1);

        // R8: reset mid-conversion aborts and keeps the result
        wait_busy(1'b0);
        keep = result;
        sample = 16'h0F0F;
        wait_busy(1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 busy cleared", busy, 1'b0);
        chk("R8 hold cleared", hold, 1'b0);
        chk("R8 result kept", result, keep);
        rst = 1'b0;
        count_to_busy(n);
        chk("R1 acquisition after abort", n, ACQ);
        chk("R8 result still kept", result, keep);
        wait_busy(1'b0);
        chk("R5 result after abort", result, 16'h0F0F);

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule